// File: doc/BRIEF.md
# Wraparound Working Stack

This block holds the working stack of a dual-stack processor core. The newest value lives in a dedicated top register. The values below it live in a ring of eight 32-bit cells, which are addressed by a rotating pointer. Each cycle the core issues one command: push a new value, pop the top, replace the top in place, swap the two upper values, or do nothing. The top value and the value just beneath it are always visible on the outputs, so an arithmetic unit can use both operands in the same cycle.

The ring never reports an error. Once more than nine values are held, each extra push silently overwrites the oldest stored cell. Pops may be issued without limit, and after the stored values are used up the earlier contents come back around in cyclic order. Programs can rely on this. For example, they can load the stack with operands once and then consume them indefinitely.

Top module: `wrap_stack`

## Requirements
- R1: While `rst_n` is low, and after it is released, `top_o` and `below_o` read 0 and every ring cell holds 0. Eight pops issued straight after reset therefore all show 0 on both outputs.
- R2: Command code 3'd1 (push), applied at a rising edge, makes `top_o` equal to that cycle's `din_i` and `below_o` equal to the previous `top_o`. Both are visible after that edge.
- R3: Command code 3'd2 (pop), applied at a rising edge, makes `top_o` equal to the previous `below_o`. No error indication exists and none is produced.
- R4: The stack holds nine values: the top register plus eight ring cells. After nine pushes, eight pops return the stored values in last-in, first-out order.
- R5: Pushing more than nine values overwrites the oldest stored values. After ten pushes, the first value pushed is no longer retrievable by any number of pops.
- R6: Pops past the stored values continue without limit. The ring contents reappear in the same cyclic order, with a period of eight pops.
- R7: Command code 3'd3 (replace) loads `din_i` into the top only. `below_o` is unchanged, and the pointer is unchanged, so a following pop returns the same value that a pop before the replace would have returned.
- R8: Command code 3'd4 (swap) exchanges the top and the value below it in one cycle. Two swaps in a row restore both outputs.
- R9: Command codes 3'd0, 3'd5, 3'd6 and 3'd7 leave `top_o`, `below_o` and the ring unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Command code: 0 idle, 1 push, 2 pop, 3 replace, 4 swap, 5..7 idle |
| din_i | input | 32 | Value for push and replace |
| top_o | output | 32 | Current top of stack |
| below_o | output | 32 | Ring cell just below the top |

## Verification
If the rotating pointer holds the wrong value, `below_o` shows the wrong cell on the very next cycle. A later pop then copies that wrong cell into `top_o`. A write to the wrong ring cell stays hidden until pops reach that cell, so the bench drains the ring completely and keeps popping past the end. This exposes misplaced or lost writes within at most eight pops. A top register that loads on the wrong command is seen one edge later on `top_o`.

// File: rtl/wstk_pkg.sv
package wstk_pkg;
  localparam int unsigned CELL_W = 32;
  localparam int unsigned RING_N = 8;

  typedef enum logic [2:0] {
    CMD_IDLE = 3'd0,
    CMD_PUSH = 3'd1,
    CMD_POP  = 3'd2,
    CMD_REPL = 3'd3,
    CMD_SWAP = 3'd4
  } wstk_cmd_e;
endpackage

// File: rtl/wstk_ptr.sv
module wstk_ptr #(
  parameter int unsigned DEPTH = wstk_pkg::RING_N,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_up,
  input  logic          step_dn,
  output logic [PW-1:0] ptr_q,
  output logic [PW-1:0] ptr_up
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + PW'(1);
  endfunction

  function automatic logic [PW-1:0] wrap_dec(input logic [PW-1:0] p);
    return (p == '0) ? LAST : p - PW'(1);
  endfunction

  assign ptr_up = wrap_inc(ptr_q);

  always_ff @(posedge clk) begin
    if (!rst_n)       ptr_q <= '0;
    else if (step_up) ptr_q <= ptr_up;
    else if (step_dn) ptr_q <= wrap_dec(ptr_q);
  end
endmodule

// File: rtl/wstk_ring.sv
module wstk_ring #(
  parameter int unsigned DEPTH = wstk_pkg::RING_N,
  parameter int unsigned W     = wstk_pkg::CELL_W,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_sel,
  input  logic [W-1:0]  wr_val,
  input  logic [PW-1:0] rd_sel,
  output logic [W-1:0]  rd_val
);
  logic [W-1:0] cell_q [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rst_n)                              cell_q[k] <= '0;
      else if (wr_en && (wr_sel == PW'(k)))    cell_q[k] <= wr_val;
    end
  end

  assign rd_val = cell_q[rd_sel];
endmodule

// File: rtl/wstk_top.sv
module wstk_top #(
  parameter int unsigned W = wstk_pkg::CELL_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take_in,
  input  logic         take_ring,
  input  logic [W-1:0] in_val,
  input  logic [W-1:0] ring_val,
  output logic [W-1:0] t_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)         t_q <= '0;
    else if (take_in)   t_q <= in_val;
    else if (take_ring) t_q <= ring_val;
  end
endmodule

// File: rtl/wrap_stack.sv
module wrap_stack #(
  parameter int unsigned DEPTH = wstk_pkg::RING_N,
  parameter int unsigned W     = wstk_pkg::CELL_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   op_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] top_o,
  output logic [W-1:0] below_o
);
  import wstk_pkg::*;
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic ev_push, ev_pop, ev_repl, ev_swap;
  logic [PW-1:0] ptr_q, ptr_up, ring_wsel;
  logic ring_we;
  logic [W-1:0] t_q, ring_rd;

  always_comb begin
    ev_push = 1'b0;
    ev_pop  = 1'b0;
    ev_repl = 1'b0;
    ev_swap = 1'b0;
    unique case (op_i)
      CMD_PUSH: ev_push = 1'b1;
      CMD_POP:  ev_pop  = 1'b1;
      CMD_REPL: ev_repl = 1'b1;
      CMD_SWAP: ev_swap = 1'b1;
      default:  ;
    endcase
  end

  // push stores old top one slot up; swap stores it at the current slot
  assign ring_we   = ev_push | ev_swap;
  assign ring_wsel = ev_push ? ptr_up : ptr_q;

  wstk_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .step_up(ev_push), .step_dn(ev_pop),
    .ptr_q(ptr_q), .ptr_up(ptr_up)
  );

  wstk_ring #(.DEPTH(DEPTH), .W(W)) u_ring (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ring_we), .wr_sel(ring_wsel), .wr_val(t_q),
    .rd_sel(ptr_q), .rd_val(ring_rd)
  );

  wstk_top #(.W(W)) u_top (
    .clk(clk), .rst_n(rst_n),
    .take_in(ev_push | ev_repl), .take_ring(ev_pop | ev_swap),
    .in_val(din_i), .ring_val(ring_rd), .t_q(t_q)
  );

  assign top_o   = t_q;
  assign below_o = ring_rd;
endmodule

// File: rtl/wrap_stack_chk.sv
module wrap_stack_chk #(
  parameter int unsigned W  = 32,
  parameter int unsigned PW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    op_i,
  input logic [W-1:0]  din_i,
  input logic [W-1:0]  top_o,
  input logic [W-1:0]  below_o,
  input logic [PW-1:0] ptr_q
);
  p_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == 3'd1 |=> top_o == $past(din_i) && below_o == $past(top_o));

  p_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == 3'd2 |=> top_o == $past(below_o));

  p_ptr_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == 3'd1 |=> ptr_q == PW'($past(ptr_q) + 1'b1));

  p_ptr_dn_r6: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == 3'd2 |=> ptr_q == PW'($past(ptr_q) - 1'b1));

  p_repl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == 3'd3 |=> top_o == $past(din_i) && $stable(below_o) && $stable(ptr_q));

  p_swap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == 3'd4 |=> top_o == $past(below_o) && below_o == $past(top_o));

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd0 || op_i > 3'd4) |=> $stable(top_o) && $stable(below_o) && $stable(ptr_q));
endmodule

bind wrap_stack wrap_stack_chk #(.W(W), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_i(op_i), .din_i(din_i),
  .top_o(top_o), .below_o(below_o), .ptr_q(ptr_q)
);

// File: tb/wrap_stack_bench.sv
`timescale 1ns/1ps
module wrap_stack_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] op_i = 3'd0;
  logic [31:0] din_i = '0;
  logic [31:0] top_o, below_o;

  always #2.5 clk = ~clk;

  wrap_stack u_wrap_stack (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .din_i(din_i),
    .top_o(top_o), .below_o(below_o)
  );

  typedef struct {
    logic [31:0] t;
    logic [31:0] b;
    string tag;
  } exp_t;

  exp_t sb[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [31:0] m_t;
  logic [31:0] m_ring [8];
  int m_p;

  task automatic model(input logic [2:0] op, input logic [31:0] d);
    logic [31:0] tmp;
    case (op)
      3'd1: begin m_p = (m_p + 1) % 8; m_ring[m_p] = m_t; m_t = d; end
      3'd2: begin m_t = m_ring[m_p]; m_p = (m_p + 7) % 8; end
      3'd3: m_t = d;
      3'd4: begin tmp = m_t; m_t = m_ring[m_p]; m_ring[m_p] = tmp; end
      default: ;
    endcase
  endtask

  task automatic drive(input logic [2:0] op, input logic [31:0] d, input string tag);
    exp_t e;
    @(negedge clk);
    op_i = op;
    din_i = d;
    model(op, d);
    e.t = m_t;
    e.b = m_ring[m_p];
    e.tag = tag;
    sb.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        n_chk++;
        if (top_o !== e.t || below_o !== e.b) begin
          n_bad++;
          $display("FAIL %s: top=%h below=%h expected top=%h below=%h",
                   e.tag, top_o, below_o, e.t, e.b);
        end
      end
    end
  end

  initial begin : watchdog
    #(5.0 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] lcg;
    m_t = '0;
    m_p = 0;
    for (int k = 0; k < 8; k++) m_ring[k] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (top_o !== 32'd0 || below_o !== 32'd0) begin
      n_bad++;
      $display("FAIL R1: top=%h below=%h expected top=0 below=0", top_o, below_o);
    end
    rst_n = 1'b1;

    // R1: drain after reset shows zeros everywhere
    for (int k = 0; k < 8; k++) drive(3'd2, 32'hDEAD_0000, "R1");

    // R2 / R4 / R5: ten pushes overflow the nine-deep stack
    for (int k = 1; k <= 10; k++) drive(3'd1, 32'hA000_0000 + k, "R2_R5");
    // R3 / R4: LIFO drain, then R6: wrap past the end twice
    for (int k = 0; k < 8; k++) drive(3'd2, '0, "R3_R4");
    for (int k = 0; k < 16; k++) drive(3'd2, '0, "R6_R5");

    // R4: exact nine-deep round trip
    for (int k = 1; k <= 9; k++) drive(3'd1, 32'hB000_0000 + k, "R4");
    for (int k = 0; k < 8; k++) drive(3'd2, '0, "R4");

    // R7: replace keeps pointer and below value
    drive(3'd1, 32'h1111_1111, "R2");
    drive(3'd3, 32'h2222_2222, "R7");
    drive(3'd3, 32'h3333_3333, "R7");
    drive(3'd2, '0, "R7");

    // R8: swap and swap back
    drive(3'd1, 32'h4444_4444, "R2");
    drive(3'd4, '0, "R8");
    drive(3'd4, '0, "R8");
    drive(3'd4, '0, "R8");
    drive(3'd2, '0, "R8");

    // R9: idle codes, then pops prove ring untouched
    drive(3'd0, 32'hFFFF_FFFF, "R9");
    drive(3'd5, 32'hFFFF_FFFF, "R9");
    drive(3'd6, 32'hFFFF_FFFF, "R9");
    drive(3'd7, 32'hFFFF_FFFF, "R9");
    for (int k = 0; k < 8; k++) drive(3'd2, '0, "R9");

    // mixed traffic
    lcg = 32'h1234_5678;
    for (int k = 0; k < 300; k++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      drive(lcg[30:28], lcg, "R2_R3_R7_R8_R9");
    end

    drive(3'd0, '0, "R9");
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule